// File: doc/BRIEF.md
# Auto-Incrementing Viterbi RAM Access Port

This block gives a host a way to load and inspect the storage of a Viterbi coprocessor. It contains three memories: two path RAMs that are 16 bits wide, and one path-metric RAM whose entries hold a 22-bit metric. The host sees all three through a single 24-bit data port and a single address counter.

To use it, the host first loads a start address and picks the target RAM. It then issues a run of data writes or data reads. Each accepted access moves the address to the next location and wraps to zero past the last entry of the selected RAM, so a whole RAM can be filled or dumped without reloading the address. In the metric RAM the address is the trellis state number, so a sequential dump lists the metrics of states 0, 1, 2 and onward. Data accesses are honoured only while the grant input `acc_mode` is high, which models the decoding engine handing the RAMs to the host.

Top module: `vcop_ram_port`

## Requirements
- R1: After reset, `addr_q` is 0, `dat_rdata` is 0 and the select is path RAM A.
- R2: `sel_we` loads the RAM select from `sel_wdata`: code 0 picks path RAM A, code 1 picks path RAM B, code 2 picks the metric RAM. A write of code 3 is ignored and the previous select stays in force. Select and address loads are accepted whether or not `acc_mode` is high.
- R3: With `acc_mode` high, `dat_we` stores `dat_wdata` at `addr_q` in the selected RAM. `addr_q` advances by one on the same clock edge.
- R4: With `acc_mode` high, `dat_re` (without `dat_we`) returns the word at `addr_q` on `dat_rdata` one clock edge later. `addr_q` advances by one on that same edge.
- R5: An access at the last location of the selected RAM sets `addr_q` to 0. The last location is PATH_DEPTH-1 for the path RAMs (63 by default) and METRIC_DEPTH-1 for the metric RAM (31 by default). An access at any higher address also sets `addr_q` to 0.
- R6: A path RAM write keeps only `dat_wdata[15:0]`. A path RAM read returns the stored word in bits 15:0 and zeros in bits 23:16.
- R7: A metric RAM write keeps `dat_wdata[21:0]`. A metric read returns it in bits 21:0 and zeros in bits 23:22. Address J holds the metric of state J, so sequential reads return states 0 through METRIC_DEPTH-1 in order.
- R8: With `acc_mode` low, `dat_we` and `dat_re` have no effect: no RAM changes, `addr_q` holds and `dat_rdata` holds.
- R9: When `dat_we` and `dat_re` are both high, only the write is performed, `addr_q` advances once and `dat_rdata` holds.
- R10: An access to a metric address at or above METRIC_DEPTH stores nothing and reads back 0.
- R11: When `addr_we` is high, `addr_q` takes `addr_wdata`, and any data access in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_mode | input | 1 | Grant: memory access mode active |
| sel_we | input | 1 | Load RAM select |
| sel_wdata | input | 2 | Select code: 0 path A, 1 path B, 2 metric |
| addr_we | input | 1 | Load address counter |
| addr_wdata | input | 6 | Start address |
| dat_we | input | 1 | Data write strobe |
| dat_wdata | input | 24 | Write data |
| dat_re | input | 1 | Data read strobe |
| dat_rdata | output | 24 | Read data, zero-extended |
| addr_q | output | 6 | Current access address |

## Verification
The bench goes after the wrap points of both RAM sizes. A design that wraps at the wrong limit would put the next word past the end of the metric RAM, or back at location 0 of a path RAM too soon. It drives writes and reads with `acc_mode` low and strobes that collide in the same cycle. A port that ignored the grant, or that gave a read priority over a write or over an address load, would alter stored words or step the address twice. Write data carries ones in the upper bits so that a missing zero-extension shows up on readback. The illegal select code and an out-of-range metric address are also exercised, since a design that took code 3 or indexed past the metric array would return foreign data.

// File: rtl/vcop_ram_port.sv
module vcop_ram_port #(
  parameter int PATH_DEPTH   = 64,
  parameter int METRIC_DEPTH = 32,
  parameter int PATH_W       = 16,
  parameter int METRIC_W     = 22,
  parameter int BUS_W        = 24,
  localparam int AW  = $clog2(PATH_DEPTH > METRIC_DEPTH ? PATH_DEPTH : METRIC_DEPTH),
  localparam int PAW = $clog2(PATH_DEPTH),
  localparam int MAW = $clog2(METRIC_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_mode,
  input  logic             sel_we,
  input  logic [1:0]       sel_wdata,
  input  logic             addr_we,
  input  logic [AW-1:0]    addr_wdata,
  input  logic             dat_we,
  input  logic [BUS_W-1:0] dat_wdata,
  input  logic             dat_re,
  output logic [BUS_W-1:0] dat_rdata,
  output logic [AW-1:0]    addr_q
);

  localparam logic [1:0] SEL_PA = 2'd0;
  localparam logic [1:0] SEL_PB = 2'd1;
  localparam logic [1:0] SEL_MT = 2'd2;
  localparam logic [AW-1:0] P_LAST = AW'(PATH_DEPTH - 1);
  localparam logic [AW-1:0] M_LAST = AW'(METRIC_DEPTH - 1);

  logic [PATH_W-1:0]   ram_a [PATH_DEPTH];
  logic [PATH_W-1:0]   ram_b [PATH_DEPTH];
  logic [METRIC_W-1:0] ram_m [METRIC_DEPTH];

  logic [1:0]       sel_q;
  logic [AW-1:0]    last;
  logic             in_range, step, wr_fire, rd_fire;
  logic [BUS_W-1:0] rd_word;
  logic [PAW-1:0]   pidx;
  logic [MAW-1:0]   midx;

  assign last     = (sel_q == SEL_MT) ? M_LAST : P_LAST;
  assign in_range = addr_q <= last;
  assign step     = acc_mode & (dat_we | dat_re) & ~addr_we;
  assign wr_fire  = step & dat_we;
  assign rd_fire  = step & ~dat_we;
  assign pidx     = addr_q[PAW-1:0];
  assign midx     = addr_q[MAW-1:0];

  always_comb begin
    rd_word = '0;
    if (in_range) begin
      case (sel_q)
        SEL_PA:  rd_word = {{(BUS_W-PATH_W){1'b0}}, ram_a[pidx]};
        SEL_PB:  rd_word = {{(BUS_W-PATH_W){1'b0}}, ram_b[pidx]};
        default: rd_word = {{(BUS_W-METRIC_W){1'b0}}, ram_m[midx]};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_fire && in_range) begin
      case (sel_q)
        SEL_PA:  ram_a[pidx] <= dat_wdata[PATH_W-1:0];
        SEL_PB:  ram_b[pidx] <= dat_wdata[PATH_W-1:0];
        default: ram_m[midx] <= dat_wdata[METRIC_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q     <= SEL_PA;
      addr_q    <= '0;
      dat_rdata <= '0;
    end else begin
      if (sel_we && sel_wdata != 2'd3) sel_q <= sel_wdata;
      if (addr_we)    addr_q <= addr_wdata;
      else if (step)  addr_q <= (addr_q >= last) ? '0 : addr_q + 1'b1;
      if (rd_fire)    dat_rdata <= rd_word;
    end
  end

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) sel_q != 2'd3); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !sel_we && addr_q < last) |=> addr_q == $past(addr_q) + 1'b1); // R3
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !sel_we && addr_q >= last) |=> addr_q == '0); // R5
  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_mode && !addr_we) |=> $stable(addr_q)); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_mode && dat_re && !dat_we && !addr_we) |=> $stable(dat_rdata)); // R9
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    addr_we |=> addr_q == $past(addr_wdata)); // R11
  AST_PATH_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && sel_q != SEL_MT) |=> dat_rdata[BUS_W-1:PATH_W] == '0); // R6
  AST_METRIC_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && sel_q == SEL_MT) |=> dat_rdata[BUS_W-1:METRIC_W] == '0); // R7

endmodule

// File: tb/test_vcop_ram_port.sv
`timescale 1ns/1ps
module test_vcop_ram_port;
  logic clk = 0, rst_n = 0;
  logic acc_mode = 0, sel_we = 0, addr_we = 0, dat_we = 0, dat_re = 0;
  logic [1:0] sel_wdata = 0;
  logic [5:0] addr_wdata = 0;
  logic [23:0] dat_wdata = 0;
  logic [23:0] dat_rdata;
  logic [5:0] addr_q;

  int checks = 0, fails = 0;
  bit done = 0;
  logic fire_q = 0;
  logic [23:0] exp_q[$];
  string tag_q[$];
  logic [23:0] held;

  always #2.5 clk = ~clk;

  vcop_ram_port i_vcop_ram_port (
    .clk(clk), .rst_n(rst_n), .acc_mode(acc_mode), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .addr_we(addr_we), .addr_wdata(addr_wdata), .dat_we(dat_we), .dat_wdata(dat_wdata),
    .dat_re(dat_re), .dat_rdata(dat_rdata), .addr_q(addr_q));

  task automatic chk(string r, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  always @(posedge clk) fire_q <= rst_n & acc_mode & dat_re & ~dat_we & ~addr_we;

  always @(negedge clk) begin
    if (fire_q && exp_q.size() > 0) begin
      logic [23:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, dat_rdata, e);
    end
  end

  task automatic cyc(bit we, bit re, bit lda, logic [5:0] la, logic [23:0] wd,
                     logic [23:0] exp, string tag);
    @(negedge clk);
    dat_we = we; dat_re = re; addr_we = lda; addr_wdata = la; dat_wdata = wd; sel_we = 0;
    if (re && !we && !lda && acc_mode) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    dat_we = 0; dat_re = 0; addr_we = 0; sel_we = 0;
  endtask

  task automatic set_addr(logic [5:0] a);
    cyc(0, 0, 1, a, 0, 0, "");
  endtask

  task automatic set_sel(logic [1:0] s);
    @(negedge clk);
    dat_we = 0; dat_re = 0; addr_we = 0; sel_we = 1; sel_wdata = s;
  endtask

  function automatic logic [23:0] pa(int i); return 24'hA50000 | 24'(i * 16'h0F0F + 3); endfunction
  function automatic logic [23:0] pb(int i); return 24'h5A0000 | 24'(i * 16'h1357 + 9); endfunction
  function automatic logic [23:0] mt(int i); return 24'hC00000 | 24'(i * 22'h01F1E3 + 1); endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 addr", {18'd0, addr_q}, 0);
    chk("R1 rdata", dat_rdata, 0);
    rst_n = 1;
    acc_mode = 1;
    // R1 select defaults to path A; R3 R6 sequential path A writes
    set_addr(2);
    for (int i = 2; i < 8; i++) cyc(1, 0, 0, 0, pa(i), 0, "");
    idle();
    chk("R3 addr advance", {18'd0, addr_q}, 8);
    set_sel(1);
    set_addr(2);
    for (int i = 2; i < 8; i++) cyc(1, 0, 0, 0, pb(i), 0, "");
    set_sel(0);
    set_addr(2);
    for (int i = 2; i < 8; i++) cyc(0, 1, 0, 0, 0, pa(i) & 24'h00FFFF, "R4 R6 path A read");
    idle();
    chk("R4 addr advance", {18'd0, addr_q}, 8);
    set_sel(1);
    set_addr(2);
    for (int i = 2; i < 8; i++) cyc(0, 1, 0, 0, 0, pb(i) & 24'h00FFFF, "R2 R6 path B read");
    // R5 path wrap at 63
    set_addr(62);
    for (int i = 62; i < 65; i++) cyc(1, 0, 0, 0, pb(i), 0, "");
    idle();
    chk("R5 path wrap", {18'd0, addr_q}, 1);
    set_addr(63);
    cyc(0, 1, 0, 0, 0, pb(63) & 24'h00FFFF, "R5 read last");
    cyc(0, 1, 0, 0, 0, pb(64) & 24'h00FFFF, "R5 read wrapped");
    // R7 metric fill and dump, R5 wrap at 31
    set_sel(2);
    set_addr(0);
    for (int i = 0; i < 32; i++) cyc(1, 0, 0, 0, mt(i), 0, "");
    idle();
    chk("R5 metric wrap", {18'd0, addr_q}, 0);
    for (int i = 0; i < 32; i++) cyc(0, 1, 0, 0, 0, mt(i) & 24'h3FFFFF, "R7 state order");
    idle();
    chk("R5 metric wrap read", {18'd0, addr_q}, 0);
    // R2 code 3 ignored: select stays metric
    set_sel(3);
    set_addr(5);
    cyc(0, 1, 0, 0, 0, mt(5) & 24'h3FFFFF, "R2 code 3 ignored");
    // R10 out of range metric address
    set_addr(40);
    cyc(1, 0, 0, 0, 24'h3FFFFF, 0, "");
    set_addr(40);
    cyc(0, 1, 0, 0, 0, 24'h0, "R10 out of range read");
    idle();
    chk("R10 addr wraps", {18'd0, addr_q}, 0);
    set_addr(8);
    cyc(0, 1, 0, 0, 0, mt(8) & 24'h3FFFFF, "R10 no alias write");
    // R8 grant low
    set_sel(0);
    set_addr(3);
    idle();
    held = dat_rdata;
    acc_mode = 0;
    cyc(1, 0, 0, 0, 24'hFFFFFF, 0, "");
    cyc(0, 1, 0, 0, 0, 0, "");
    idle();
    chk("R8 addr held", {18'd0, addr_q}, 3);
    chk("R8 rdata held", dat_rdata, held);
    acc_mode = 1;
    cyc(0, 1, 0, 0, 0, pa(3) & 24'h00FFFF, "R8 ram untouched");
    // R9 simultaneous read and write
    set_addr(4);
    idle();
    held = dat_rdata;
    cyc(1, 1, 0, 0, 24'h00BEEF, 0, "");
    idle();
    chk("R9 single step", {18'd0, addr_q}, 5);
    chk("R9 rdata held", dat_rdata, held);
    set_addr(4);
    cyc(0, 1, 0, 0, 0, 24'h00BEEF, "R9 write done");
    // R11 load wins over access
    set_addr(6);
    cyc(1, 0, 1, 10, 24'h001111, 0, "");
    idle();
    chk("R11 loaded addr", {18'd0, addr_q}, 10);
    set_addr(6);
    cyc(0, 1, 0, 0, 0, pa(6) & 24'h00FFFF, "R11 write dropped");
    idle();
    idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule